// File: doc/BRIEF.md
# Indexed codec control register file

This block is the control register file of an audio codec, reached by a host through a window of four byte ports. The host writes a register number into the index port and then reads or writes the selected register through the data port. The index port also holds a mode-change-enable flag and reports a busy condition. A busy condition covers the start-up period after reset and the resynchronization period after a format write.

There are 32 indirect registers. In basic mode only the lower 16 are reachable, and numbers 16 to 31 fold onto 0 to 15. Setting bit 6 of register 12 opens the enhanced bank, in which all 32 are distinct.

Some bits are read-only:
- register 1 bit 4;
- register 12 bit 7, which always reads 1;
- the revision nibble of register 12;
- register 11 bit 5, the calibration flag.

Clearing the mode-change-enable flag starts an auto-calibration. During it, register 11 bit 5 reads 1 for a fixed number of cycles. All busy and calibration periods are timed by down-counters whose lengths are parameters.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After the internal reset release, two clock edges after rst_n rises, the index port (bus_addr=0) reads 0x80 for INIT_CYCLES clock edges. After that it reads 0x00.
- R2: Registers 0 to 15 reset to A8 A8 08 08 08 08 80 80 00 08 02 00 8A 01 00 00 (hex) as read through the data port.
- R3: A write to the data port (bus_addr=1) stores bus_wdata into the register selected by the index. A later read of the data port returns it.
- R4: Register 1 bit 4 is read-only. A write leaves it at its stored value, 0 after reset.
- R5: Register 12 reads bit 7 as 1 and bits 3:0 as REV_CODE. Only bits 6:4 are writable, and bit 6 set selects the enhanced bank.
- R6: In basic mode (register 12 bit 6 clear), index i+16 selects the same register as index i for reads and writes.
- R7: In enhanced mode, indices 16 to 31 are separate registers. Registers 16 to 19 reset to 80 00 10 10 and the rest of them to 00.
- R8: While a resynchronization or the start-up period is running, the index port reads exactly 0x80.
- R9: A data-port write to register 8 starts a resynchronization of RSY_CYCLES clock edges. In enhanced mode, a write to register 28 does the same. In basic mode, index 24 folds onto 8 and also starts one.
- R10: An index-port write that clears bit 6 while the flag is set starts a calibration. Register 11 bit 5 reads 1 for CAL_CYCLES clock edges and then 0. Writes never change that bit.
- R11: The status port (bus_addr=2) and polled port (bus_addr=3) read 0x00. Writes to them change no register and no index.
- R12: When not busy, the index port reads {0, flag, 0, index[4:0]}. A write that sets the flag, or keeps it clear, starts no calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Port select: 0 index, 1 data, 2 status, 3 polled |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected port, combinational from state and bus_addr |

## Verification
A write lands on the clock edge where bus_wr is seen, and reads are combinational. Every read result is therefore due in the same cycle, and the bench samples it at the falling edge after the address settles. Busy and calibration flags rise on that same edge and stay up for exactly the parameterised number of edges. The bench checks the flag one edge before its expected fall and again at the fall, and a behavioural model is compared on every falling edge. Start-up busy begins counting only on the third rising edge after rst_n rises, because of the reset synchronizer, and the model reproduces that delay.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int DW          = 8;
  localparam int IDX_W       = 5;
  localparam int NUM_REGS    = 1 << IDX_W;
  localparam int FMT_IDX     = 8;
  localparam int CAP_FMT_IDX = 28;
  localparam int CAL_IDX     = 11;
  localparam int CFG_IDX     = 12;
  localparam int RO_BIT_IDX  = 1;
  localparam int MODE_BIT    = 6;
  localparam int CAL_BIT     = 5;
  localparam int MCE_BIT     = 6;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_POLL   = 2'd3
  } port_e;

  function automatic logic [DW-1:0] reset_value(input int i);
    case (i)
      0, 1:       return 8'hA8;
      2, 3, 4, 5: return 8'h08;
      6, 7:       return 8'h80;
      9:          return 8'h08;
      10:         return 8'h02;
      12:         return 8'h8A;
      13:         return 8'h01;
      16:         return 8'h80;
      18, 19:     return 8'h10;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] write_mask(input int i);
    case (i)
      RO_BIT_IDX: return 8'hEF;
      CAL_IDX:    return 8'hDF;
      CFG_IDX:    return 8'h70;
      default:    return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/codec_busy_timer.sv
module codec_busy_timer #(
  parameter int CYCLES     = 16,
  parameter bit START_BUSY = 1'b0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i)
      cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= START_BUSY ? CW'(CYCLES) : '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/codec_index_port.sv
module codec_index_port
  import codec_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_wdata_i,
  input  logic             mce_wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             mce_o,
  output logic             cal_start_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             mce_q, mce_d;

  always_comb begin
    idx_d = wr_i ? idx_wdata_i : idx_q;
    mce_d = wr_i ? mce_wdata_i : mce_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      mce_q <= 1'b0;
    end else if (wr_i) begin
      idx_q <= idx_d;
      mce_q <= mce_d;
    end
  end

  assign cal_start_o = wr_i && mce_q && !mce_wdata_i;
  assign idx_o       = idx_q;
  assign mce_o       = mce_q;
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_regs_pkg::*;
#(
  parameter logic [3:0] REV_CODE = 4'hA
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             cal_busy_i,
  output logic [DW-1:0]    rdata_o,
  output logic             enh_o
);
  logic [DW-1:0] regs_w [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] RV = reset_value(g);
    localparam logic [DW-1:0] WM = write_mask(g);
    logic [DW-1:0] q, d;
    logic          en;

    always_comb begin
      en = wr_i && (addr_i == IDX_W'(g));
      d  = (q & ~WM) | (wdata_i & WM);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)
        q <= RV;
      else if (en)
        q <= d;
    end

    assign regs_w[g] = q;
  end

  logic [DW-1:0] raw;

  always_comb begin
    raw = regs_w[addr_i];
    if (addr_i == IDX_W'(CFG_IDX))
      rdata_o = {1'b1, raw[6:4], REV_CODE};
    else if (addr_i == IDX_W'(CAL_IDX))
      rdata_o = {raw[7:6], cal_busy_i, raw[4:0]};
    else
      rdata_o = raw;
  end

  assign enh_o = regs_w[CFG_IDX][MODE_BIT];
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_regs_pkg::*;
#(
  parameter int         INIT_CYCLES = 20,
  parameter int         RSY_CYCLES  = 12,
  parameter int         CAL_CYCLES  = 40,
  parameter logic [3:0] REV_CODE    = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             idx_wr, data_wr;
  logic [IDX_W-1:0] idx, eff_idx;
  logic             mce, enh, cal_start, rsy_start;
  logic             init_busy, rsy_busy, cal_busy, busy;
  logic [DW-1:0]    bank_rdata;

  assign idx_wr  = bus_wr && (bus_addr == PORT_INDEX);
  assign data_wr = bus_wr && (bus_addr == PORT_DATA);

  codec_index_port u_index (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .wr_i        (idx_wr),
    .idx_wdata_i (bus_wdata[IDX_W-1:0]),
    .mce_wdata_i (bus_wdata[MCE_BIT]),
    .idx_o       (idx),
    .mce_o       (mce),
    .cal_start_o (cal_start)
  );

  assign eff_idx   = enh ? idx : {1'b0, idx[IDX_W-2:0]};
  assign rsy_start = data_wr && ((eff_idx == IDX_W'(FMT_IDX)) ||
                                 (enh && eff_idx == IDX_W'(CAP_FMT_IDX)));

  codec_busy_timer #(.CYCLES(INIT_CYCLES), .START_BUSY(1'b1)) u_init_tmr (
    .clk(clk), .rst_ni(rst_sync_n), .load_i(1'b0), .busy_o(init_busy));

  codec_busy_timer #(.CYCLES(RSY_CYCLES), .START_BUSY(1'b0)) u_rsy_tmr (
    .clk(clk), .rst_ni(rst_sync_n), .load_i(rsy_start), .busy_o(rsy_busy));

  codec_busy_timer #(.CYCLES(CAL_CYCLES), .START_BUSY(1'b0)) u_cal_tmr (
    .clk(clk), .rst_ni(rst_sync_n), .load_i(cal_start), .busy_o(cal_busy));

  codec_reg_bank #(.REV_CODE(REV_CODE)) u_bank (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .wr_i       (data_wr),
    .addr_i     (eff_idx),
    .wdata_i    (bus_wdata),
    .cal_busy_i (cal_busy),
    .rdata_o    (bank_rdata),
    .enh_o      (enh)
  );

  assign busy = init_busy || rsy_busy;

  always_comb begin
    case (bus_addr)
      PORT_INDEX: bus_rdata = busy ? 8'h80 : {1'b0, mce, 1'b0, idx};
      PORT_DATA:  bus_rdata = bank_rdata;
      default:    bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/codec_ctrl_regs_chk.sv
module codec_ctrl_regs_chk #(
  parameter logic [3:0] REV_CODE = 4'hA
) (
  input logic       clk,
  input logic       rst_ni,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic [4:0] eff_idx,
  input logic       enh,
  input logic       mce,
  input logic       busy,
  input logic       rsy_busy,
  input logic       cal_busy
);
  // R8
  busy_idx_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && bus_addr == 2'd0) |-> bus_rdata == 8'h80);

  // R9
  rsy_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rsy_busy) |-> $past(bus_wr && bus_addr == 2'd1 &&
                              (eff_idx == 5'd8 || eff_idx == 5'd28)));

  // R10
  cal_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(cal_busy) |-> ($past(mce) && !mce));

  // R10
  cal_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr == 2'd1 && eff_idx == 5'd11) |-> bus_rdata[5] == cal_busy);

  // R5
  cfg_ro_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr == 2'd1 && eff_idx == 5'd12) |->
      (bus_rdata[7] && bus_rdata[3:0] == REV_CODE));

  // R4
  ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr == 2'd1 && eff_idx == 5'd1) |-> !bus_rdata[4]);

  // R6
  alias_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !enh |-> !eff_idx[4]);

  // R11
  aux_port_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_addr[1] |-> bus_rdata == 8'h00);
endmodule

bind codec_ctrl_regs codec_ctrl_regs_chk #(.REV_CODE(REV_CODE)) chk_i (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .eff_idx   (eff_idx),
  .enh       (enh),
  .mce       (mce),
  .busy      (busy),
  .rsy_busy  (rsy_busy),
  .cal_busy  (cal_busy)
);

// File: tb/codec_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module codec_ctrl_regs_tb_top;
  localparam int INIT = 20;
  localparam int RSY  = 12;
  localparam int CAL  = 40;
  localparam logic [3:0] REV = 4'hA;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  codec_ctrl_regs #(.INIT_CYCLES(INIT), .RSY_CYCLES(RSY),
                    .CAL_CYCLES(CAL), .REV_CODE(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [7:0] exp_reset(input int i);
    logic [7:0] t [16] = '{8'hA8, 8'hA8, 8'h08, 8'h08, 8'h08, 8'h08, 8'h80, 8'h80,
                           8'h00, 8'h08, 8'h02, 8'h00, 8'h8A, 8'h01, 8'h00, 8'h00};
    if (i < 16) return t[i];
    if (i == 16) return 8'h80;
    if (i == 18 || i == 19) return 8'h10;
    return 8'h00;
  endfunction

  // behavioural reference model
  logic [7:0] m_reg [32];
  int m_idx, m_mce, m_init, m_rsy, m_cal, m_rel;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    int e;
    logic [7:0] v;
    if (a == 2'd0)
      return (m_init > 0 || m_rsy > 0) ? 8'h80 : 8'((m_mce << 6) | m_idx);
    if (a != 2'd1) return 8'h00;
    e = m_reg[12][6] ? m_idx : (m_idx % 16);
    v = m_reg[e];
    if (e == 12) v = {1'b1, v[6:4], REV};
    if (e == 11) v[5] = (m_cal > 0);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_reg[i] = exp_reset(i);
      m_idx = 0; m_mce = 0; m_init = INIT; m_rsy = 0; m_cal = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      logic enh;
      int e;
      enh = m_reg[12][6];
      if (m_init > 0) m_init--;
      if (m_rsy > 0) m_rsy--;
      if (m_cal > 0) m_cal--;
      if (bus_wr && bus_addr == 2'd0) begin
        if (m_mce == 1 && !bus_wdata[6]) m_cal = CAL;
        m_mce = bus_wdata[6];
        m_idx = bus_wdata[4:0];
      end
      if (bus_wr && bus_addr == 2'd1) begin
        e = enh ? m_idx : (m_idx % 16);
        if (e == 1)       m_reg[1]  = (bus_wdata & 8'hEF) | (m_reg[1] & 8'h10);
        else if (e == 11) m_reg[11] = (bus_wdata & 8'hDF) | (m_reg[11] & 8'h20);
        else if (e == 12) m_reg[12] = (m_reg[12] & 8'h8F) | (bus_wdata & 8'h70);
        else              m_reg[e]  = bus_wdata;
        if (e == 8 || (enh && e == 28)) m_rsy = RSY;
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] ex;
    ex = m_read(bus_addr);
    checks++;
    if (bus_rdata !== ex) begin
      fails++;
      $display("FAIL %s cycle model port=%0d actual=%02h expected=%02h",
               bus_addr == 2'd0 ? "R12" : (bus_addr == 2'd1 ? "R3" : "R11"),
               bus_addr, bus_rdata, ex);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    #2;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #1 rst_n = 1'b0;
    #20 rst_n = 1'b1;
    idle(1);
    rd(0, v); chk("R1 init busy", v, 8'h80);
    idle(INIT + 4);
    rd(0, v); chk("R1 after init", v, 8'h00);

    for (int i = 0; i < 16; i++) begin
      wr(0, 8'(i)); rd(1, v); chk("R2 reset value", v, exp_reset(i));
    end

    wr(0, 8'd0); wr(1, 8'hAA); rd(1, v); chk("R3 write AA", v, 8'hAA);
    wr(1, 8'h45); rd(1, v); chk("R3 write 45", v, 8'h45);
    wr(0, 8'd3); wr(1, 8'h5A); rd(1, v); chk("R3 reg3", v, 8'h5A);
    rd(0, v); chk("R12 index readback", v, 8'h03);

    wr(0, 8'd1); wr(1, 8'h55); rd(1, v); chk("R4 bit4 kept", v, 8'h45);
    wr(1, 8'hFF); rd(1, v); chk("R4 bit4 kept ff", v, 8'hEF);

    wr(0, 8'd12); wr(1, 8'h0F); rd(1, v); chk("R5 ro bits", v, 8'h8A);

    wr(0, 8'd16); rd(0, v); chk("R12 index 16", v, 8'h10);
    wr(1, 8'h33); wr(0, 8'd0); rd(1, v); chk("R6 alias 16->0", v, 8'h33);

    wr(0, 8'd12); wr(1, 8'h40); rd(1, v); chk("R5 enhanced on", v, 8'hCA);
    wr(0, 8'd16); rd(1, v); chk("R7 reg16 reset", v, 8'h80);
    wr(1, 8'h77); wr(0, 8'd0); rd(1, v); chk("R7 reg0 untouched", v, 8'h33);
    wr(0, 8'd18); rd(1, v); chk("R7 reg18 reset", v, 8'h10);

    wr(0, 8'd28); wr(1, 8'h12); rd(0, v); chk("R8 busy after reg28", v, 8'h80);
    idle(RSY - 1); rd(0, v); chk("R9 still busy", v, 8'h80);
    idle(1); rd(0, v); chk("R9 resync end", v, 8'h1C);
    rd(1, v); chk("R3 reg28", v, 8'h12);

    wr(0, 8'd8); wr(1, 8'h5B); rd(0, v); chk("R9 reg8 busy", v, 8'h80);
    idle(RSY); rd(0, v); chk("R9 reg8 end", v, 8'h08);

    wr(0, 8'd12); wr(1, 8'h00); rd(1, v); chk("R5 basic again", v, 8'h8A);
    wr(0, 8'd24); wr(1, 8'h21); rd(0, v); chk("R9 alias 24 busy", v, 8'h80);
    idle(RSY);
    wr(0, 8'd8); rd(1, v); chk("R6 alias 24->8", v, 8'h21);

    wr(0, 8'h4B); rd(1, v); chk("R12 set flag no cal", v, 8'h00);
    rd(0, v); chk("R12 flag readback", v, 8'h4B);
    wr(0, 8'h0B); rd(1, v); chk("R10 cal start", v, 8'h20);
    idle(CAL - 1); rd(1, v); chk("R10 cal last", v, 8'h20);
    idle(1); rd(1, v); chk("R10 cal end", v, 8'h00);
    wr(1, 8'hFF); rd(1, v); chk("R10 bit5 ignored", v, 8'hDF);
    wr(0, 8'h0B); rd(1, v); chk("R12 clear-to-clear no cal", v, 8'hDF);

    wr(2, 8'hFF); rd(2, v); chk("R11 status port", v, 8'h00);
    wr(3, 8'h55); rd(3, v); chk("R11 poll port", v, 8'h00);
    rd(0, v); chk("R11 index untouched", v, 8'h0B);
    wr(0, 8'd0); rd(1, v); chk("R11 reg0 untouched", v, 8'h33);

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule